// File: doc/BRIEF.md
# Supervisor memory region permission checker

This block decides whether one physical memory access may proceed under a table of supervisor-level protection entries. Every entry has a configuration byte (read, write, execute, user and lock bits plus a two-bit address-matching mode) and an address register in 4-byte word units. An entry takes part only when its bit in a 64-bit switch vector is set and its mode is not off. The configuration bytes, the address registers and the switch vector come in already decoded from a register bank outside this block.

Each cycle the block compares the access address against every live entry. Entries use one of three region shapes: a range bounded by the previous entry's register, a single 4-byte word, or a naturally aligned power-of-two region whose size is encoded by trailing ones. The lowest-numbered matching entry decides the outcome. That entry's permission bit for the access kind is then applied. The whole check sits behind a gate: an access that did not pass the machine-level protection check is always refused. The result is registered, so it appears one cycle after the access is presented.

Top module: `smpu_checker`

## Requirements
- R1: While `rst` is high, and on the first cycle after it has been high, `allow` and `fault` are 0 and `hit_idx` is 0.
- R2: The result for the inputs presented in cycle n appears on the outputs in cycle n+1. When `acc_valid` was 0, both `allow` and `fault` are 0.
- R3: When `pmp_pass` was 0 for a valid access, the access is refused (`fault`=1) whatever the entries hold.
- R4: Entry i is live only when `entry_switch[i]` is 1 and its mode field (configuration bits 4:3) is nonzero. An entry that is not live never matches.
- R5: Mode 2 (single word): entry i matches exactly the 4 bytes starting at `addr_regs` entry i shifted left by 2.
- R6: Mode 3 (power of two): with t trailing ones in the register, the region is 2^(t+3) bytes, based at the register with its low t bits cleared and shifted left by 2.
- R7: Mode 1 (range): entry i matches when the previous entry's register shifted left by 2 is <= the address and the address is < entry i's register shifted left by 2. Entry 0 uses 0 as its lower bound.
- R8: When several entries match, the lowest-numbered one decides. `hit_idx` reports its index, or 0 when nothing matches.
- R9: The deciding entry's permission is bit 0 for read (`acc_kind`=0), bit 1 for write (`acc_kind`=1) and bit 2 for execute (`acc_kind`=2). `acc_kind`=3 is always refused.
- R10: A user access (`acc_user`=1) considers only entries whose bit 6 is set. A supervisor access considers every live entry.
- R11: A valid access that matches no considered entry is refused.
- R12: `fault` is 1 exactly when the access was valid and not allowed. `allow` and `fault` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Physical byte address of the access |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| acc_user | input | 1 | 1 for a user-level access, 0 for supervisor |
| pmp_pass | input | 1 | Access already passed the machine-level check |
| cfg_bytes | input | NUM_ENTRIES*8 | Configuration byte of each entry, entry i in bits 8i+7:8i |
| addr_regs | input | NUM_ENTRIES*(ADDR_W-2) | Address register of each entry, in word units |
| entry_switch | input | 64 | Per-entry on/off switch vector |
| allow | output | 1 | Access permitted (registered) |
| fault | output | 1 | Valid access refused (registered) |
| hit_idx | output | $clog2(NUM_ENTRIES) | Index of the deciding entry, 0 when none |

## Verification
The block holds no state apart from the output register, so a fault in its logic shows at the ports in the very next cycle. It appears as a wrong `allow`/`fault` pair or a wrong `hit_idx` for the access just presented. Stale output from a broken register stage shows up when idle cycles and gated accesses follow permitted ones. A wrong region decode or priority order shows up only for addresses at region edges and in overlaps, so the stimulus targets the first and last words of each region, the word just outside it, and overlapping entries, under both privilege levels.

// File: rtl/smpu_pkg.sv
package smpu_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_RANGE = 2'd1,
    MODE_WORD  = 2'd2,
    MODE_POW2  = 2'd3
  } match_mode_e;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_EXEC  = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;

  // bit 7 lock, bit 6 user, bit 5 spare, bits 4:3 mode, bit 2 x, bit 1 w, bit 0 r
  typedef struct packed {
    logic        lock;
    logic        user;
    logic        spare;
    match_mode_e mode;
    logic        x;
    logic        w;
    logic        r;
  } entry_cfg_t;

endpackage

// File: rtl/smpu_entry_match.sv
module smpu_entry_match
  import smpu_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic [REG_W-1:0] word_addr,
  input  match_mode_e      mode,
  input  logic             user_bit,
  input  logic [REG_W-1:0] this_reg,
  input  logic [REG_W-1:0] prev_reg,
  input  logic             sw_on,
  input  logic             user_acc,
  output logic             hit
);

  logic [REG_W-1:0] pow2_mask;
  logic             live;
  logic             in_region;

  always_comb begin
    // trailing ones plus the first zero above them
    pow2_mask = this_reg ^ (this_reg + REG_W'(1));
    live      = sw_on && (mode != MODE_OFF) && (!user_acc || user_bit);
    unique case (mode)
      MODE_RANGE: in_region = (word_addr >= prev_reg) && (word_addr < this_reg);
      MODE_WORD:  in_region = (word_addr == this_reg);
      MODE_POW2:  in_region = ((word_addr ^ this_reg) & ~pow2_mask) == '0;
      default:    in_region = 1'b0;
    endcase
    hit = live && in_region;
  end

endmodule

// File: rtl/smpu_prio_pick.sv
module smpu_prio_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (any) begin
      a_r8_pick_is_requested: assert (req[idx]);
      a_r8_nothing_lower: assert ((req & ((N'(1) << idx) - N'(1))) == '0);
    end
  end

endmodule

// File: rtl/smpu_checker.sv
module smpu_checker
  import smpu_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 34,
  parameter bit REG_OUT     = 1'b1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              acc_valid,
  input  logic [ADDR_W-1:0]                 acc_addr,
  input  logic [1:0]                        acc_kind,
  input  logic                              acc_user,
  input  logic                              pmp_pass,
  input  logic [NUM_ENTRIES*8-1:0]          cfg_bytes,
  input  logic [NUM_ENTRIES*(ADDR_W-2)-1:0] addr_regs,
  input  logic [63:0]                       entry_switch,
  output logic                              allow,
  output logic                              fault,
  output logic [$clog2(NUM_ENTRIES)-1:0]    hit_idx
);

  localparam int REG_W = ADDR_W - 2;
  localparam int IDX_W = $clog2(NUM_ENTRIES);

  entry_cfg_t       cfg_arr [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] hit_vec;
  logic [REG_W-1:0] word_addr;
  logic             any_hit;
  logic [IDX_W-1:0] pick_idx;
  entry_cfg_t       sel_cfg;
  logic             perm_ok;
  logic             allow_c;
  logic             fault_c;

  assign word_addr = acc_addr[ADDR_W-1:2];

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    logic [REG_W-1:0] prev_r;
    assign cfg_arr[i] = entry_cfg_t'(cfg_bytes[i*8 +: 8]);
    if (i == 0) begin : g_first
      assign prev_r = '0;
    end else begin : g_rest
      assign prev_r = addr_regs[(i-1)*REG_W +: REG_W];
    end
    smpu_entry_match #(.REG_W(REG_W)) u_match (
      .word_addr (word_addr),
      .mode      (cfg_arr[i].mode),
      .user_bit  (cfg_arr[i].user),
      .this_reg  (addr_regs[i*REG_W +: REG_W]),
      .prev_reg  (prev_r),
      .sw_on     (entry_switch[i]),
      .user_acc  (acc_user),
      .hit       (hit_vec[i])
    );
  end

  smpu_prio_pick #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick (
    .req (hit_vec),
    .any (any_hit),
    .idx (pick_idx)
  );

  always_comb begin
    sel_cfg = cfg_arr[pick_idx];
    unique case (acc_kind_e'(acc_kind))
      KIND_READ:  perm_ok = sel_cfg.r;
      KIND_WRITE: perm_ok = sel_cfg.w;
      KIND_EXEC:  perm_ok = sel_cfg.x;
      default:    perm_ok = 1'b0;
    endcase
    allow_c = acc_valid && pmp_pass && any_hit && perm_ok;
    fault_c = acc_valid && !allow_c;
  end

  logic unused_bits;
  assign unused_bits = ^{entry_switch[63:NUM_ENTRIES], acc_addr[1:0],
                         sel_cfg.lock, sel_cfg.spare};

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        allow   <= 1'b0;
        fault   <= 1'b0;
        hit_idx <= '0;
      end else begin
        allow   <= allow_c;
        fault   <= fault_c;
        hit_idx <= pick_idx;
      end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
      $past(rst) |-> (!allow && !fault && hit_idx == '0));

    a_r12_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(allow && fault));

    a_r3_pmp_gate: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(acc_valid && !pmp_pass)) |-> fault);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(acc_valid)) |-> (!allow && !fault));

    a_r4_live_switch: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && allow) |-> ((($past(entry_switch) >> hit_idx) & 64'd1) != 64'd0));

    a_r10_user_bit: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && allow && $past(acc_user)) |->
        ((($past(cfg_bytes) >> ({3'd0, hit_idx} * 8 + 6)) & 1) != 0));
  end else begin : g_comb
    assign allow   = allow_c;
    assign fault   = fault_c;
    assign hit_idx = pick_idx;
    always_comb begin
      a_r12_exclusive_c: assert (!(allow && fault));
    end
  end

endmodule

// File: tb/smpu_checker_tb.sv
`timescale 1ns/1ps
module smpu_checker_tb;

  localparam int N = 8;
  localparam int AW = 34;
  localparam int RW = AW - 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0]    acc_kind = 2'd0;
  logic          acc_user = 1'b0;
  logic          pmp_pass = 1'b0;
  logic [N*8-1:0]  cfg_bus;
  logic [N*RW-1:0] reg_bus;
  logic [63:0]   sw = '0;
  logic          allow, fault;
  logic [2:0]    hit_idx;

  logic [7:0]    cfgs [N];
  logic [RW-1:0] regs [N];

  integer errors = 0;
  integer checks = 0;
  bit     done = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      cfg_bus[i*8 +: 8]   = cfgs[i];
      reg_bus[i*RW +: RW] = regs[i];
    end
  end

  smpu_checker u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_kind(acc_kind), .acc_user(acc_user), .pmp_pass(pmp_pass),
    .cfg_bytes(cfg_bus), .addr_regs(reg_bus), .entry_switch(sw),
    .allow(allow), .fault(fault), .hit_idx(hit_idx)
  );

  function automatic void model(input logic [AW-1:0] a, input logic [1:0] k,
                                input logic u, input logic p, input logic v,
                                output logic ea, output logic ef, output logic [2:0] ei);
    longint unsigned wa, lo, hi, base, size;
    integer found, t;
    logic [1:0] md;
    logic perm;
    found = -1;
    wa = longint'(a >> 2);
    for (int i = 0; i < N; i++) begin
      md = cfgs[i][4:3];
      if (found >= 0) break;
      if (!sw[i] || md == 2'd0) continue;
      if (u && !cfgs[i][6]) continue;
      hi = longint'(regs[i]);
      lo = (i == 0) ? 0 : longint'(regs[i-1]);
      if (md == 2'd1) begin
        if (wa >= lo && wa < hi) found = i;
      end else if (md == 2'd2) begin
        if (wa == hi) found = i;
      end else begin
        t = 0;
        while (t < RW && regs[i][t]) t++;
        size = 64'd1 << (t + 1);
        base = hi / size;
        if (wa / size == base) found = i;
      end
    end
    perm = 1'b0;
    if (found >= 0) begin
      if (k == 2'd0) perm = cfgs[found][0];
      else if (k == 2'd1) perm = cfgs[found][1];
      else if (k == 2'd2) perm = cfgs[found][2];
    end
    ea = v && p && (found >= 0) && perm;
    ef = v && !ea;
    ei = (found >= 0) ? 3'(found) : 3'd0;
  endfunction

  task automatic compare(input logic ea, input logic ef, input logic [2:0] ei, input string tag);
    checks++;
    if (allow !== ea || fault !== ef || hit_idx !== ei) begin
      errors++;
      $display("FAIL %s addr=%h kind=%0d user=%0d: got allow=%b fault=%b idx=%0d, expected allow=%b fault=%b idx=%0d",
               tag, acc_addr, acc_kind, acc_user, allow, fault, hit_idx, ea, ef, ei);
    end
  endtask

  task automatic step(input logic [AW-1:0] a, input logic [1:0] k, input logic u,
                      input logic p, input logic v, input string tag);
    logic ea, ef;
    logic [2:0] ei;
    acc_addr = a; acc_kind = k; acc_user = u; pmp_pass = p; acc_valid = v;
    model(a, k, u, p, v, ea, ef, ei);
    @(posedge clk);
    #2;
    compare(ea, ef, ei, tag);
    @(negedge clk);
  endtask

  task automatic rand_cfg();
    integer t;
    for (int i = 0; i < N; i++) begin
      cfgs[i] = 8'($urandom) & 8'hDF;
      t = $urandom_range(0, 4);
      regs[i] = RW'($urandom_range(0, 4095));
      regs[i] = (regs[i] & ~((RW'(1) << (t + 1)) - RW'(1))) | ((RW'(1) << t) - RW'(1));
    end
    sw = {56'd0, 8'($urandom)};
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin cfgs[i] = 8'h00; regs[i] = '0; end
    // R1: reset holds outputs low
    repeat (2) @(posedge clk);
    #2;
    compare(1'b0, 1'b0, 3'd0, "R1");
    @(negedge clk);
    rst = 1'b0;

    // directed table: bit0 r, bit1 w, bit2 x, bits4:3 mode, bit6 user
    cfgs[0] = 8'h11; regs[0] = 32'h400;   // word at 0x1000, read, supervisor only
    cfgs[1] = 8'h5B; regs[1] = 32'h81F;   // pow2 0x2000..0x20FF, rw, user
    cfgs[2] = 8'h0C; regs[2] = 32'hC00;   // range 0x207C..0x2FFF, exec
    cfgs[3] = 8'h17; regs[3] = 32'h1000;  // word at 0x4000, switched off
    cfgs[4] = 8'h07; regs[4] = 32'h1400;  // mode off at 0x5000
    cfgs[5] = 8'h59; regs[5] = 32'h2000;  // pow2 8 bytes at 0x8000, read, user
    sw = 64'hF7;

    step(34'h1000, 2'd0, 1'b0, 1'b1, 1'b1, "R5");
    step(34'h1004, 2'd0, 1'b0, 1'b1, 1'b1, "R5");
    step(34'h0FFC, 2'd0, 1'b0, 1'b1, 1'b1, "R11");
    step(34'h1000, 2'd1, 1'b0, 1'b1, 1'b1, "R9");
    step(34'h1000, 2'd3, 1'b0, 1'b1, 1'b1, "R9");
    step(34'h1000, 2'd0, 1'b1, 1'b1, 1'b1, "R10");
    step(34'h2000, 2'd1, 1'b1, 1'b1, 1'b1, "R6");
    step(34'h20FF, 2'd0, 1'b1, 1'b1, 1'b1, "R6");
    step(34'h2080, 2'd2, 1'b0, 1'b1, 1'b1, "R8");
    step(34'h2100, 2'd0, 1'b0, 1'b1, 1'b1, "R7");
    step(34'h2100, 2'd2, 1'b0, 1'b1, 1'b1, "R7");
    step(34'h2FFC, 2'd2, 1'b0, 1'b1, 1'b1, "R7");
    step(34'h3000, 2'd2, 1'b0, 1'b1, 1'b1, "R7");
    step(34'h2100, 2'd2, 1'b1, 1'b1, 1'b1, "R10");
    step(34'h4000, 2'd0, 1'b0, 1'b1, 1'b1, "R4");
    step(34'h5000, 2'd0, 1'b0, 1'b1, 1'b1, "R4");
    step(34'h8004, 2'd0, 1'b1, 1'b1, 1'b1, "R6");
    step(34'h8008, 2'd0, 1'b1, 1'b1, 1'b1, "R6");
    step(34'h1000, 2'd0, 1'b0, 1'b0, 1'b1, "R3");
    step(34'h2000, 2'd1, 1'b1, 1'b0, 1'b1, "R3");
    step(34'h1000, 2'd0, 1'b0, 1'b1, 1'b0, "R2");
    step(34'h1000, 2'd0, 1'b0, 1'b1, 1'b1, "R12");
    step(34'h0000, 2'd0, 1'b0, 1'b1, 1'b0, "R12");

    // R7: entry 0 in range mode starts at address 0
    cfgs[0] = 8'h09; regs[0] = 32'h100;
    step(34'h0000, 2'd0, 1'b0, 1'b1, 1'b1, "R7");
    step(34'h03FC, 2'd0, 1'b0, 1'b1, 1'b1, "R7");
    step(34'h0400, 2'd0, 1'b0, 1'b1, 1'b1, "R7");
    sw[3] = 1'b1;
    step(34'h4000, 2'd1, 1'b0, 1'b1, 1'b1, "R4");

    // mixed patterns around region edges
    for (int n = 0; n < 600; n++) begin
      int j;
      logic [AW-1:0] a;
      if (n % 40 == 0) rand_cfg();
      j = $urandom_range(0, N - 1);
      a = {2'b00, regs[j]} << 2;
      a = a + AW'($urandom_range(0, 48)) - AW'(24);
      step(a, 2'($urandom), 1'($urandom), ($urandom_range(0, 9) != 0),
           ($urandom_range(0, 7) != 0), "R8");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule